// File: doc/BRIEF.md
# Quad DAC Serial Load Controller

This block is the digital front end of a four-channel, 12-bit converter. A host sends fixed-length frames over a three-wire serial link: a frame strobe (active low), a serial clock and a data line. The block decodes each frame either as a write to one channel register or as a readback request, and it presents 12-bit codes, output-enable flags and range selections to the analog stages that follow it. All serial inputs are brought into the system clock domain and edge-detected there.

Each channel has a latest-write register, a pending register and an output register. A load pin selects between two update modes. When the pin is low, a data write reaches the output as soon as the frame ends. When the pin is high, the first data write to each channel is held for a joint update, and that update happens when the pin is taken low. Later writes in the same window are kept for readback only. An optional 8-bit check field lengthens the frame to 32 bits. A shared clear code, together with per-channel clear enables, lets a clear pulse force chosen outputs to a known value. After reset a busy window runs, and frames that end inside it are refused.

Top module: `dac_serial_ctrl`

## Requirements
- R1: After reset, every channel code is 0, every output enable is 0, every range field is 0 (0 V to 5 V), sdo_o is 0, early_o and pec_err_o are 0, and busy_o is 1.
- R2: busy_o stays high for BUSY_CYCLES clock cycles after reset is released, then stays low. A frame that ends while busy_o is high changes no register and sets early_o, which then holds until reset.
- R3: A frame is shifted in MSB first, with sdin_i sampled on falling edges of sclk_i while sync_i is low. Bit 23 is read/write (0 = write), bits 22:21 are the channel, bits 20:16 are the register select, and bits 15:0 are data. For a data write (select 0) the code is bits 15:4 and bits 3:0 are ignored. With ldac_i low, the addressed channel's code_o updates after sync_i rises and the other channels are unchanged.
- R4: A frame whose count of falling sclk_i edges is not exactly 24 (or 32 when pec_en_i is high) is discarded with no register change.
- R5: While ldac_i is high, only the first data write to each channel after ldac_i rose is captured for the pending update, and code_o does not change. When ldac_i falls, every channel that captured a write updates its code_o together. Channels with no capture keep their code.
- R6: A read frame (bit 23 = 1) loads the 24-bit word {1, channel, select, field} into the readback shifter. During the next frame, sdo_o presents one bit per rising sclk_i edge, MSB first. For select 0 the field is the latest data write {code, 4'b0}, including writes ignored by R5.
- R7: With pec_en_i high, a frame carries 24 data bits followed by an 8-bit CRC. The CRC uses polynomial x^8+x^2+x+1 (0x07), initial value 0, and is computed over the 24 bits MSB first. A mismatching frame is rejected and sets pec_err_o, which then holds until reset.
- R8: A write to select 2 sets the channel's range_o from bits 2:0, its en_o from bit 3 and its clear enable from bit 4, and takes effect after the frame regardless of ldac_i. A readback of select 2 returns these fields in bits 4:0.
- R9: A write to select 1 stores the shared clear code from bits 15:4. A rising edge on clear_i loads that code into code_o of every channel whose clear enable is set, and leaves the other channels unchanged.
- R10: A write to any select other than 0, 1 or 2 changes no code, enable or range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sync_i | input | 1 | Frame strobe, active low |
| sclk_i | input | 1 | Serial clock |
| sdin_i | input | 1 | Serial data in |
| ldac_i | input | 1 | Load pin: low for individual updates, high to collect a joint update |
| clear_i | input | 1 | Rising edge forces clear-enabled channels to the clear code |
| pec_en_i | input | 1 | Enables the 8-bit frame check |
| sdo_o | output | 1 | Serial readback data |
| code_o | output | NCH*DW | Channel output codes, channel i at [i*DW +: DW] |
| en_o | output | NCH | Per-channel output enable |
| range_o | output | NCH*3 | Per-channel range select, channel i at [i*3 +: 3] |
| busy_o | output | 1 | High during the post-reset busy window |
| early_o | output | 1 | Sticky: a frame ended while busy |
| pec_err_o | output | 1 | Sticky: a frame failed its CRC |

## Verification
The hardest state to reach is a channel whose readback value differs from its output and from its pending value. Getting there takes the load pin held high across two writes to the same channel, a write to a second channel, and only then the falling edge of the pin. The stimulus builds that sequence, checks that the outputs stay frozen while the pin is high, checks which values appear after the fall, and then reads the channel back through a read frame and a dummy frame, so that the later, ignored write shows up on sdo_o. Rejected frames (short, long, bad CRC, too early) are each followed by port checks that show no register moved.

// File: rtl/dac_pkg.sv
package dac_pkg;
  localparam int FRAME_W = 24;
  localparam int CRC_W   = 8;
  localparam int SEL_W   = 5;
  localparam int FIELD_W = 16;
  localparam int CH_W    = 2;
  localparam int RNG_W   = 3;

  localparam logic [SEL_W-1:0] SEL_DATA = 5'h00;
  localparam logic [SEL_W-1:0] SEL_CLR  = 5'h01;
  localparam logic [SEL_W-1:0] SEL_CTRL = 5'h02;

  // CRC-8, poly 0x07, init 0, MSB first
  function automatic logic [CRC_W-1:0] crc8_f(input logic [FRAME_W-1:0] d);
    logic [CRC_W-1:0] c;
    logic fb;
    c = '0;
    for (int i = FRAME_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ d[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ 8'h07;
    end
    return c;
  endfunction
endpackage

// File: rtl/dac_frame_rx.sv
module dac_frame_rx
  import dac_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sync_i,
  input  logic               sclk_i,
  input  logic               sdin_i,
  input  logic               pec_en_i,
  output logic               sclk_rise_o,
  output logic               active_o,
  output logic               sync_rise_o,
  output logic               done_o,
  output logic               crc_bad_o,
  output logic [FRAME_W-1:0] word_o
);
  localparam int TOT_W = FRAME_W + CRC_W;
  localparam int CNT_W = $clog2(TOT_W + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [2:0] sync_q, sclk_q;
  logic [1:0] din_q;
  logic [CNT_W-1:0] cnt_q;
  logic [TOT_W-1:0] sh_q;
  logic sclk_fall, sync_fall, len_ok, crc_ok;
  logic [FRAME_W-1:0] data_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 3'b111;
      sclk_q <= 3'b000;
      din_q  <= 2'b00;
    end else begin
      sync_q <= {sync_q[1:0], sync_i};
      sclk_q <= {sclk_q[1:0], sclk_i};
      din_q  <= {din_q[0], sdin_i};
    end
  end

  assign sclk_fall   = sclk_q[2] & ~sclk_q[1];
  assign sclk_rise_o = ~sclk_q[2] & sclk_q[1];
  assign sync_fall   = sync_q[2] & ~sync_q[1];
  assign sync_rise_o = ~sync_q[2] & sync_q[1];
  assign active_o    = ~sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (sync_fall) begin
      cnt_q <= '0;
    end else if (sclk_fall && active_o) begin
      sh_q <= {sh_q[TOT_W-2:0], din_q[1]};
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign data_w = pec_en_i ? sh_q[TOT_W-1:CRC_W] : sh_q[FRAME_W-1:0];
  assign len_ok = pec_en_i ? (cnt_q == CNT_W'(TOT_W)) : (cnt_q == CNT_W'(FRAME_W));
  assign crc_ok = ~pec_en_i | (crc8_f(sh_q[TOT_W-1:CRC_W]) == sh_q[CRC_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o    <= 1'b0;
      crc_bad_o <= 1'b0;
      word_o    <= '0;
    end else begin
      done_o    <= sync_rise_o & len_ok & crc_ok;
      crc_bad_o <= sync_rise_o & len_ok & ~crc_ok;
      if (sync_rise_o) word_o <= data_w;
    end
  end
endmodule

// File: rtl/dac_sdo_shift.sv
module dac_sdo_shift
  import dac_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] word_i,
  input  logic               sclk_rise_i,
  input  logic               active_i,
  input  logic               sync_rise_i,
  output logic               sdo_o
);
  logic [FRAME_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      sdo_o <= 1'b0;
    end else begin
      if (load_i) begin
        sh_q <= word_i;
      end else if (sclk_rise_i && active_i) begin
        sdo_o <= sh_q[FRAME_W-1];
        sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
      end
      if (sync_rise_i) sdo_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dac_reg_bank.sv
module dac_reg_bank
  import dac_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_i,
  input  logic [FRAME_W-1:0] word_i,
  input  logic               ldac_i,
  input  logic               clear_i,
  output logic [NCH*DW-1:0]  code_o,
  output logic [NCH-1:0]     en_o,
  output logic [NCH*RNG_W-1:0] range_o,
  output logic               rb_load_o,
  output logic [FRAME_W-1:0] rb_word_o
);
  logic               rw;
  logic [CH_W-1:0]    ch;
  logic [SEL_W-1:0]   sel;
  logic [FIELD_W-1:0] fld;
  logic [DW-1:0]      code_w;

  assign rw     = word_i[FRAME_W-1];
  assign ch     = word_i[FRAME_W-2 -: CH_W];
  assign sel    = word_i[FIELD_W +: SEL_W];
  assign fld    = word_i[FIELD_W-1:0];
  assign code_w = fld[FIELD_W-1 -: DW];

  logic [2:0] ldac_q, clr_q;
  logic ldac_lvl, ldac_rise, upd_all, clr_rise, wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ldac_q <= '0;
      clr_q  <= '0;
    end else begin
      ldac_q <= {ldac_q[1:0], ldac_i};
      clr_q  <= {clr_q[1:0], clear_i};
    end
  end

  assign ldac_lvl  = ldac_q[1];
  assign ldac_rise = ldac_q[1] & ~ldac_q[2];
  assign upd_all   = ~ldac_q[1] & ldac_q[2];
  assign clr_rise  = clr_q[1] & ~clr_q[2];
  assign wr        = cmd_i & ~rw;

  logic [DW-1:0] clr_code_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clr_code_q <= '0;
    else if (wr && sel == SEL_CLR) clr_code_q <= code_w;
  end

  logic [DW-1:0]    data_q [NCH];
  logic [DW-1:0]    pend_q [NCH];
  logic [DW-1:0]    out_q  [NCH];
  logic [RNG_W-1:0] rng_q  [NCH];
  logic [NCH-1:0]   taken_q, en_q, clren_q;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit;
    assign hit = wr && (ch == CH_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q[g]  <= '0;
        pend_q[g]  <= '0;
        out_q[g]   <= '0;
        taken_q[g] <= 1'b0;
      end else begin
        if (upd_all) begin
          if (taken_q[g]) out_q[g] <= pend_q[g];
          taken_q[g] <= 1'b0;
        end else if (ldac_rise) begin
          taken_q[g] <= 1'b0;
        end
        if (clr_rise && clren_q[g]) out_q[g] <= clr_code_q;
        if (hit && sel == SEL_DATA) begin
          data_q[g] <= code_w;
          if (!ldac_lvl) begin
            out_q[g] <= code_w;
          end else if (!taken_q[g]) begin
            pend_q[g]  <= code_w;
            taken_q[g] <= 1'b1;
          end
        end
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rng_q[g]   <= '0;
        en_q[g]    <= 1'b0;
        clren_q[g] <= 1'b0;
      end else if (hit && sel == SEL_CTRL) begin
        rng_q[g]   <= fld[RNG_W-1:0];
        en_q[g]    <= fld[RNG_W];
        clren_q[g] <= fld[RNG_W+1];
      end
    end

    assign code_o[g*DW +: DW]         = out_q[g];
    assign range_o[g*RNG_W +: RNG_W]  = rng_q[g];
  end

  assign en_o = en_q;

  logic [FIELD_W-1:0] rd_fld;
  always_comb begin
    rd_fld = '0;
    for (int i = 0; i < NCH; i++) begin
      if (ch == CH_W'(i)) begin
        case (sel)
          SEL_DATA: rd_fld = FIELD_W'({data_q[i], {(FIELD_W-DW){1'b0}}});
          SEL_CTRL: rd_fld = FIELD_W'({clren_q[i], en_q[i], rng_q[i]});
          default:  rd_fld = '0;
        endcase
      end
    end
    if (sel == SEL_CLR) rd_fld = FIELD_W'({clr_code_q, {(FIELD_W-DW){1'b0}}});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rb_load_o <= 1'b0;
      rb_word_o <= '0;
    end else begin
      rb_load_o <= cmd_i & rw;
      if (cmd_i && rw) rb_word_o <= {1'b1, ch, sel, rd_fld};
    end
  end
endmodule

// File: rtl/dac_serial_ctrl.sv
module dac_serial_ctrl
  import dac_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int DW          = 12,
  parameter int BUSY_CYCLES = 5000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sync_i,
  input  logic                 sclk_i,
  input  logic                 sdin_i,
  input  logic                 ldac_i,
  input  logic                 clear_i,
  input  logic                 pec_en_i,
  output logic                 sdo_o,
  output logic [NCH*DW-1:0]    code_o,
  output logic [NCH-1:0]       en_o,
  output logic [NCH*RNG_W-1:0] range_o,
  output logic                 busy_o,
  output logic                 early_o,
  output logic                 pec_err_o
);
  localparam int BW = $clog2(BUSY_CYCLES + 1);

  logic sclk_rise, active, sync_rise, done, crc_bad, frm_ok, rb_load;
  logic [FRAME_W-1:0] word, rb_word;
  logic [BW-1:0] busy_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_cnt_q <= '0;
    else if (busy_o) busy_cnt_q <= busy_cnt_q + 1'b1;
  end
  assign busy_o = (busy_cnt_q != BW'(BUSY_CYCLES));

  assign frm_ok = done & ~busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      early_o   <= 1'b0;
      pec_err_o <= 1'b0;
    end else begin
      if (busy_o && (done || crc_bad)) early_o <= 1'b1;
      if (!busy_o && crc_bad) pec_err_o <= 1'b1;
    end
  end

  dac_frame_rx u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_i     (sync_i),
    .sclk_i     (sclk_i),
    .sdin_i     (sdin_i),
    .pec_en_i   (pec_en_i),
    .sclk_rise_o(sclk_rise),
    .active_o   (active),
    .sync_rise_o(sync_rise),
    .done_o     (done),
    .crc_bad_o  (crc_bad),
    .word_o     (word)
  );

  dac_reg_bank #(.NCH(NCH), .DW(DW)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmd_i    (frm_ok),
    .word_i   (word),
    .ldac_i   (ldac_i),
    .clear_i  (clear_i),
    .code_o   (code_o),
    .en_o     (en_o),
    .range_o  (range_o),
    .rb_load_o(rb_load),
    .rb_word_o(rb_word)
  );

  dac_sdo_shift u_sdo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (rb_load),
    .word_i     (rb_word),
    .sclk_rise_i(sclk_rise),
    .active_i   (active),
    .sync_rise_i(sync_rise),
    .sdo_o      (sdo_o)
  );
endmodule

// File: rtl/dac_serial_ctrl_chk.sv
module dac_serial_ctrl_chk #(
  parameter int NCH = 4,
  parameter int DW  = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_o,
  input logic             early_o,
  input logic             pec_err_o,
  input logic             frm_ok,
  input logic [NCH*DW-1:0] code_o,
  input logic [NCH-1:0]   en_o,
  input logic [NCH*3-1:0] range_o
);
  p_busy_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(code_o) && $stable(en_o) && $stable(range_o)));

  p_busy_once_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> !busy_o);

  p_early_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    early_o |=> early_o);

  p_pec_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pec_err_o |=> pec_err_o);

  p_ctrl_by_frame_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frm_ok |=> ($stable(en_o) && $stable(range_o)));
endmodule

bind dac_serial_ctrl dac_serial_ctrl_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .busy_o   (busy_o),
  .early_o  (early_o),
  .pec_err_o(pec_err_o),
  .frm_ok   (frm_ok),
  .code_o   (code_o),
  .en_o     (en_o),
  .range_o  (range_o)
);

// File: tb/dac_serial_ctrl_tb.sv
module dac_serial_ctrl_tb;
  localparam int NCH = 4;
  localparam int DW  = 12;
  localparam int BUSY = 5000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sync_i = 1'b1, sclk_i = 1'b0, sdin_i = 1'b0;
  logic ldac_i = 1'b0, clear_i = 1'b0, pec_en_i = 1'b0;
  logic sdo_o, busy_o, early_o, pec_err_o;
  logic [NCH*DW-1:0] code_o;
  logic [NCH-1:0] en_o;
  logic [NCH*3-1:0] range_o;

  int total = 0;
  int bad = 0;
  logic [23:0] rx;

  always #10 clk = ~clk;

  dac_serial_ctrl #(.NCH(NCH), .DW(DW), .BUSY_CYCLES(BUSY)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sync_i(sync_i), .sclk_i(sclk_i),
    .sdin_i(sdin_i), .ldac_i(ldac_i), .clear_i(clear_i), .pec_en_i(pec_en_i),
    .sdo_o(sdo_o), .code_o(code_o), .en_o(en_o), .range_o(range_o),
    .busy_o(busy_o), .early_o(early_o), .pec_err_o(pec_err_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] crc(input logic [23:0] d);
    logic [7:0] c = 8'h00;
    for (int i = 23; i >= 0; i--) begin
      if (c[7] ^ d[i]) c = {c[6:0], 1'b0} ^ 8'h07;
      else c = {c[6:0], 1'b0};
    end
    return c;
  endfunction

  function automatic logic [23:0] wf(input logic [1:0] ch, input logic [4:0] sel, input logic [15:0] f);
    return {1'b0, ch, sel, f};
  endfunction

  function automatic logic [23:0] rf(input logic [1:0] ch, input logic [4:0] sel);
    return {1'b1, ch, sel, 16'h0000};
  endfunction

  function automatic logic [11:0] code(input int ch);
    return code_o[ch*DW +: DW];
  endfunction

  // bits MSB-aligned in a 33-bit vector; n bits sent
  task automatic send(input logic [32:0] bits, input int n);
    rx = '0;
    sync_i = 1'b0;
    wclk(4);
    for (int i = 0; i < n; i++) begin
      sdin_i = bits[32-i];
      wclk(4);
      sclk_i = 1'b1;
      wclk(8);
      rx = {rx[22:0], sdo_o};
      sclk_i = 1'b0;
      wclk(8);
    end
    wclk(4);
    sync_i = 1'b1;
    wclk(12);
  endtask

  task automatic send24(input logic [23:0] w);
    send({w, 9'h0}, 24);
  endtask

  task automatic send32(input logic [23:0] w, input logic [7:0] c);
    send({w, c, 1'b0}, 32);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    wclk(5);
    rst_ni = 1'b1;
  endtask

  task automatic t_reset_early();
    do_reset();
    wclk(2);
    chk("R1 code", 32'(code_o), 32'h0);
    chk("R1 en", 32'(en_o), 32'h0);
    chk("R1 range", 32'(range_o), 32'h0);
    chk("R1 sdo", 32'(sdo_o), 32'h0);
    chk("R1 busy", 32'(busy_o), 32'h1);
    chk("R1 flags", {30'h0, early_o, pec_err_o}, 32'h0);
    send24(wf(2'd0, 5'h00, 16'h7770));
    chk("R2 early code", 32'(code(0)), 32'h0);
    chk("R2 early flag", 32'(early_o), 32'h1);
    chk("R2 still busy", 32'(busy_o), 32'h1);
  endtask

  task automatic t_busy_len();
    int n = 0;
    do_reset();
    while (busy_o && n < BUSY + 10) begin
      @(negedge clk);
      n++;
    end
    total++;
    if (n < BUSY - 1 || n > BUSY + 1) begin
      bad++;
      $display("FAIL R2 busy length act=%0d exp=%0d", n, BUSY);
    end
    chk("R2 early clear after reset", 32'(early_o), 32'h0);
    wclk(20);
    chk("R2 busy stays low", 32'(busy_o), 32'h0);
  endtask

  task automatic t_indiv();
    send24(wf(2'd1, 5'h00, 16'hABCF));
    chk("R3 ch1", 32'(code(1)), 32'hABC);
    chk("R3 ch0 untouched", 32'(code(0)), 32'h0);
    send24(wf(2'd3, 5'h00, 16'h1235));
    chk("R3 ch3", 32'(code(3)), 32'h123);
    chk("R3 ch1 kept", 32'(code(1)), 32'hABC);
  endtask

  task automatic t_len();
    logic [23:0] w = wf(2'd0, 5'h00, 16'h5550);
    send({w, 9'h0}, 23);
    chk("R4 short frame", 32'(code(0)), 32'h0);
    send({w, 1'b1, 8'h0}, 25);
    chk("R4 long frame", 32'(code(0)), 32'h0);
  endtask

  task automatic t_simul();
    ldac_i = 1'b1;
    wclk(10);
    send24(wf(2'd0, 5'h00, 16'h1110));
    send24(wf(2'd0, 5'h00, 16'h2220));
    send24(wf(2'd2, 5'h00, 16'h3330));
    chk("R5 held ch0", 32'(code(0)), 32'h0);
    chk("R5 held ch2", 32'(code(2)), 32'h0);
    ldac_i = 1'b0;
    wclk(10);
    chk("R5 ch0 first write", 32'(code(0)), 32'h111);
    chk("R5 ch2", 32'(code(2)), 32'h333);
    chk("R5 ch1 no capture", 32'(code(1)), 32'hABC);
    chk("R5 ch3 no capture", 32'(code(3)), 32'h123);
  endtask

  task automatic t_readback();
    send24(rf(2'd0, 5'h00));
    send24(wf(2'd0, 5'h1F, 16'h0000));
    chk("R6 readback latest ch0", 32'(rx), 32'h802220);
    send24(rf(2'd1, 5'h00));
    send24(wf(2'd0, 5'h1F, 16'h0000));
    chk("R6 readback ch1", 32'(rx), 32'hA0ABC0);
    chk("R6 ch0 output unchanged", 32'(code(0)), 32'h111);
  endtask

  task automatic t_ctrl();
    send24(wf(2'd2, 5'h02, 16'h001D));
    chk("R8 en", 32'(en_o), 32'h4);
    chk("R8 range", 32'(range_o), 32'(12'h5 << 6));
    send24(rf(2'd2, 5'h02));
    send24(wf(2'd0, 5'h1F, 16'h0000));
    chk("R8 readback", 32'(rx), 32'hC2001D);
  endtask

  task automatic t_unknown();
    send24(wf(2'd1, 5'h07, 16'hFFFF));
    chk("R10 code", 32'(code_o), {4'h0, 12'h123, 12'h333, 12'hABC, 12'h111} );
    chk("R10 en", 32'(en_o), 32'h4);
    chk("R10 range", 32'(range_o), 32'(12'h5 << 6));
  endtask

  task automatic t_clear();
    send24(wf(2'd0, 5'h01, 16'h7F00));
    chk("R9 no change before pulse", 32'(code(2)), 32'h333);
    clear_i = 1'b1;
    wclk(10);
    clear_i = 1'b0;
    wclk(10);
    chk("R9 ch2 cleared", 32'(code(2)), 32'h7F0);
    chk("R9 ch0 kept", 32'(code(0)), 32'h111);
    chk("R9 ch1 kept", 32'(code(1)), 32'hABC);
  endtask

  task automatic t_pec();
    logic [23:0] w;
    pec_en_i = 1'b1;
    wclk(4);
    w = wf(2'd0, 5'h00, 16'h4560);
    send32(w, crc(w));
    chk("R7 good crc", 32'(code(0)), 32'h456);
    chk("R7 no err", 32'(pec_err_o), 32'h0);
    w = wf(2'd0, 5'h00, 16'h9990);
    send32(w, crc(w) ^ 8'h01);
    chk("R7 bad crc rejected", 32'(code(0)), 32'h456);
    chk("R7 err flag", 32'(pec_err_o), 32'h1);
    send24(wf(2'd0, 5'h00, 16'hAAA0));
    chk("R4 24 bits with check on", 32'(code(0)), 32'h456);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset_early();
    t_busy_len();
    t_indiv();
    t_len();
    t_simul();
    t_readback();
    t_ctrl();
    t_unknown();
    t_clear();
    t_pec();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule